// File: doc/BRIEF.md
# Atomic Coefficient Safeload Controller

This block updates a group of up to five parameter RAM words so that they all change together. A running filter then never runs with part of a coefficient set old and part new. The host fills five staging slots. Each slot holds an 8-bit RAM address and a 22-bit data word. The host then pulses an arm input. Writing the slots does not start anything by itself.

Once armed, the block waits for the processing core to say that the parameter RAM is free. The core does this with a one-cycle strobe, which means that the next five cycles contain no RAM access. The block then walks the slots in order 0 to 4, one slot per cycle. It issues a RAM write only for the slots written since the last commit. After the last slot it sets a sticky done flag. Reading the status clears that flag. The host may poll the flag, but it does not have to.

Top module: `safeload_ctrl`

## Requirements
- R1: After reset, `done` is 0, `pending` is 0 and `ram_we` is 0.
- R2: A slot write with `slot_wr_idx` in 0..4, made while `pending` is 0, stores the address and the data in that slot. It also marks the slot as written. A later write to the same slot replaces the earlier values.
- R3: A pulse on `arm` while `pending` is 0 sets `pending` from the next cycle on. No RAM write happens until `core_free_start` is seen high while `pending` is 1.
- R4: If `core_free_start` is high in cycle t while armed and idle, the block commits slot i in cycle t+1+i, for i = 0..4. In that cycle `ram_we` is 1, with the slot's address on `ram_addr` and its data on `ram_wdata`. No RAM write happens outside these five cycles.
- R5: In the commit window, a slot not written since the previous commit gives `ram_we` = 0 in its cycle, whatever stale contents it holds.
- R6: In cycle t+6, `done` is 1 and `pending` is 0. All written marks are cleared, so a new arm and strobe with no new slot writes produces no RAM write.
- R7: A pulse on `status_rd` clears `done` from the next cycle on. If the read falls in the last commit cycle (t+5), `done` is 1 in cycle t+6.
- R8: Slot writes while `pending` is 1 are discarded. They do not change the data that is committed, and they do not mark the slot for the next commit.
- R9: `core_free_start` while not armed, or during a commit, has no effect. So does `arm` while `pending` is 1.
- R10: A slot write with `slot_wr_idx` of 5 or more changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_wr_en | input | 1 | Write strobe for a staging slot |
| slot_wr_idx | input | 3 | Staging slot index |
| slot_wr_addr | input | 8 | RAM address to stage |
| slot_wr_data | input | 22 | Data word to stage |
| arm | input | 1 | Initiate the transfer |
| status_rd | input | 1 | Status read; clears `done` |
| core_free_start | input | 1 | Core strobe: the next five cycles have no RAM access |
| pending | output | 1 | Transfer armed or committing |
| done | output | 1 | Sticky completion flag |
| ram_we | output | 1 | Parameter RAM write enable |
| ram_addr | output | 8 | Parameter RAM write address |
| ram_wdata | output | 22 | Parameter RAM write data |

## Verification
Slot writes, `arm` and `status_rd` each take effect one cycle after the cycle in which they are driven. The RAM write for slot i comes in cycle t+1+i after a free strobe in cycle t, and `done` rises in cycle t+6. The bench drives inputs on the falling edge and compares outputs on the falling edge of the exact cycle in which each result is due. During the waiting period it checks in every cycle that no RAM write appears. Its expected slot contents and written marks come from a bench-side model that applies the discard rules for pending writes and out-of-range indices.

// File: rtl/safeload_pkg.sv
// Package: shared sizes and the state type of the safeload controller.
// Assumes: one staging slot per coefficient of a biquad section.
package safeload_pkg;
    localparam int SL_SLOTS  = 5;
    localparam int SL_ADDR_W = 8;
    localparam int SL_DATA_W = 22;

    typedef enum logic [1:0] {
        SL_IDLE   = 2'd0,
        SL_WAIT   = 2'd1,
        SL_COMMIT = 2'd2
    } sl_state_t;
endpackage

// File: rtl/safeload_slot_bank.sv
// Module: staging slots, each holding an address, a data word and a written mark.
// Assumes: wr_en is already gated off while a transfer is pending, so a write and
// a clear never land in the same cycle. An index of NUM_SLOTS or more matches no slot.
module safeload_slot_bank #(
    parameter int NUM_SLOTS = 5,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 22,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_written,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_written
);
    logic [ADDR_W-1:0] addr_q [NUM_SLOTS];
    logic [DATA_W-1:0] data_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] written_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Store the slot contents and set the written mark on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[g]    <= '0;
                data_q[g]    <= '0;
                written_q[g] <= 1'b0;
            end else begin
                if (clr_written) begin
                    written_q[g] <= 1'b0;
                end
                if (wr_en && wr_idx == IDX_W'(g)) begin
                    addr_q[g]    <= wr_addr;
                    data_q[g]    <= wr_data;
                    written_q[g] <= 1'b1;
                end
            end
        end
    end

    // Select the slot being committed.
    always_comb begin
        rd_addr    = '0;
        rd_data    = '0;
        rd_written = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_addr    = addr_q[i];
                rd_data    = data_q[i];
                rd_written = written_q[i];
            end
        end
    end
endmodule

// File: rtl/safeload_commit_seq.sv
// Module: sequencer for arming, waiting for the free window and walking the slots.
// Assumes: free_start is a one-cycle strobe promising NUM_SLOTS access-free cycles
// that follow it. The walk visits every slot in one cycle each, starting with slot 0.
module safeload_commit_seq #(
    parameter int NUM_SLOTS = 5,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             free_start,
    output logic             busy,
    output logic             committing,
    output logic [IDX_W-1:0] idx,
    output logic             finish
);
    import safeload_pkg::*;

    sl_state_t        state_q;
    logic [IDX_W-1:0] idx_q;

    assign busy       = (state_q != SL_IDLE);
    assign committing = (state_q == SL_COMMIT);
    assign idx        = idx_q;
    assign finish     = committing && (idx_q == IDX_W'(NUM_SLOTS - 1));

    // Step the state through idle, waiting and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SL_IDLE: begin
                    if (arm) state_q <= SL_WAIT;
                end
                SL_WAIT: begin
                    if (free_start) begin
                        state_q <= SL_COMMIT;
                        idx_q   <= '0;
                    end
                end
                SL_COMMIT: begin
                    if (finish) begin
                        state_q <= SL_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= SL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/safeload_done_flag.sv
// Module: sticky completion flag, cleared by a status read.
// Assumes: when a set and a clear fall in the same cycle, the set wins.
module safeload_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic rd_clr,
    output logic done
);
    // Keep the flag until it is read; a completion in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      done <= 1'b0;
        else if (set)    done <= 1'b1;
        else if (rd_clr) done <= 1'b0;
    end
endmodule

// File: rtl/safeload_ctrl.sv
// Module: top of the atomic coefficient safeload controller.
// Assumes: the core raises core_free_start only when the next five cycles leave the
// parameter RAM untouched. RAM write outputs are combinational from the sequencer
// state and the slot bank.
module safeload_ctrl #(
    parameter int NUM_SLOTS = safeload_pkg::SL_SLOTS,
    parameter int ADDR_W    = safeload_pkg::SL_ADDR_W,
    parameter int DATA_W    = safeload_pkg::SL_DATA_W,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_wr_en,
    input  logic [IDX_W-1:0]  slot_wr_idx,
    input  logic [ADDR_W-1:0] slot_wr_addr,
    input  logic [DATA_W-1:0] slot_wr_data,
    input  logic              arm,
    input  logic              status_rd,
    input  logic              core_free_start,
    output logic              pending,
    output logic              done,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);
    logic             busy;
    logic             committing;
    logic             finish;
    logic [IDX_W-1:0] cur_idx;
    logic             cur_written;

    safeload_commit_seq #(.NUM_SLOTS(NUM_SLOTS)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .free_start (core_free_start),
        .busy       (busy),
        .committing (committing),
        .idx        (cur_idx),
        .finish     (finish)
    );

    safeload_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (slot_wr_en && !busy),
        .wr_idx      (slot_wr_idx),
        .wr_addr     (slot_wr_addr),
        .wr_data     (slot_wr_data),
        .clr_written (finish),
        .rd_idx      (cur_idx),
        .rd_addr     (ram_addr),
        .rd_data     (ram_wdata),
        .rd_written  (cur_written)
    );

    safeload_done_flag i_done (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (finish),
        .rd_clr (status_rd),
        .done   (done)
    );

    assign pending = busy;
    assign ram_we  = committing && cur_written;
endmodule

// File: rtl/safeload_ctrl_chk.sv
// Module: property checker for the safeload controller, bound to the top.
// Assumes: it observes ports only.
module safeload_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic status_rd,
    input logic pending,
    input logic done,
    input logic ram_we
);
    // R4: RAM writes happen only while a transfer is in progress.
    assert_we_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> pending);

    // R3: the first armed cycle never writes the RAM.
    assert_no_early_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> !ram_we);

    // R6: completion leaves the done flag set.
    assert_done_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> done);

    // R6: done rises only when a transfer ends.
    assert_done_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(pending));

    // R7: without a read, done stays set.
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !status_rd) |=> done);

    // R7: a read clears done unless a completion coincides.
    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status_rd) |=> (!done || $fell(pending)));
endmodule

bind safeload_ctrl safeload_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_rd (status_rd),
    .pending   (pending),
    .done      (done),
    .ram_we    (ram_we)
);

// File: tb/test_safeload_ctrl.sv
// Bench: directed corner cases plus seeded random rounds against a bench-side slot model.
module test_safeload_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_wr_en = 1'b0;
    logic [2:0]  slot_wr_idx = '0;
    logic [7:0]  slot_wr_addr = '0;
    logic [21:0] slot_wr_data = '0;
    logic        arm = 1'b0;
    logic        status_rd = 1'b0;
    logic        core_free_start = 1'b0;
    logic        pending, done, ram_we;
    logic [7:0]  ram_addr;
    logic [21:0] ram_wdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0]  m_addr [5];
    logic [21:0] m_data [5];
    bit          m_wr   [5];

    always #10 clk = ~clk;

    safeload_ctrl i_safeload_ctrl (
        .clk(clk), .rst_n(rst_n),
        .slot_wr_en(slot_wr_en), .slot_wr_idx(slot_wr_idx),
        .slot_wr_addr(slot_wr_addr), .slot_wr_data(slot_wr_data),
        .arm(arm), .status_rd(status_rd), .core_free_start(core_free_start),
        .pending(pending), .done(done), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected write enable of commit cycle i.
    function automatic bit exp_we(input int i);
        return m_wr[i];
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    // Slot write; the model applies the discard rules (R8, R10).
    task automatic wr_slot(input logic [2:0] idx, input logic [7:0] a, input logic [21:0] d);
        bit was_pending;
        was_pending = pending;
        slot_wr_en = 1'b1; slot_wr_idx = idx; slot_wr_addr = a; slot_wr_data = d;
        tick();
        slot_wr_en = 1'b0;
        if (!was_pending && idx < 5) begin
            m_addr[idx] = a; m_data[idx] = d; m_wr[idx] = 1'b1;
        end
    endtask

    task automatic do_arm();
        arm = 1'b1; tick(); arm = 1'b0;
        chk(pending == 1'b1, "R3", "pending after arm", pending, 1);
    endtask

    task automatic rd_status();
        status_rd = 1'b1; tick(); status_rd = 1'b0;
        chk(done == 1'b0, "R7", "done after read", done, 0);
    endtask

    // Strobe, then check the five commit cycles and the completion (R4, R5, R6).
    task automatic commit(input bit read_last, input bit arm_mid);
        core_free_start = 1'b1; tick(); core_free_start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(ram_we == exp_we(i), exp_we(i) ? "R4" : "R5", $sformatf("we slot %0d", i), ram_we, exp_we(i));
            if (exp_we(i)) begin
                chk(ram_addr == m_addr[i], "R4", $sformatf("addr slot %0d", i), ram_addr, m_addr[i]);
                chk(ram_wdata == m_data[i], "R4", $sformatf("data slot %0d", i), ram_wdata, m_data[i]);
            end
            core_free_start = (i == 2);  // R9: strobe during commit ignored
            arm = arm_mid && (i == 1);   // R9: arm during commit ignored
            status_rd = read_last && (i == 4);
            tick();
            core_free_start = 1'b0; arm = 1'b0; status_rd = 1'b0;
        end
        chk(done == 1'b1, read_last ? "R7" : "R6", "done at t+6", done, 1);
        chk(pending == 1'b0, arm_mid ? "R9" : "R6", "pending at t+6", pending, 0);
        chk(ram_we == 1'b0, "R4", "no write after window", ram_we, 0);
        for (int i = 0; i < 5; i++) m_wr[i] = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 5; i++) begin m_addr[i] = '0; m_data[i] = '0; m_wr[i] = 0; end
        void'($urandom(32'd2024));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(done == 0, "R1", "done reset", done, 0);
        chk(pending == 0, "R1", "pending reset", pending, 0);
        chk(ram_we == 0, "R1", "ram_we reset", ram_we, 0);

        // R9: strobe while idle does nothing.
        core_free_start = 1'b1; tick(); core_free_start = 1'b0;
        chk(ram_we == 0 && pending == 0, "R9", "idle strobe", {ram_we, pending}, 0);

        // R2 with overwrite, R10 out-of-range index, R5 partial set.
        wr_slot(3'd1, 8'h11, 22'h0AAAA);
        wr_slot(3'd1, 8'h12, 22'h1BBBB);
        wr_slot(3'd3, 8'hF0, 22'h3FFFF);
        wr_slot(3'd5, 8'h55, 22'h15555);
        wr_slot(3'd7, 8'h77, 22'h17777);
        do_arm();
        for (int k = 0; k < 4; k++) begin
            chk(ram_we == 0, "R3", "no write while waiting", ram_we, 0);
            arm = (k == 0);  // R9: extra arm ignored
            tick();
            arm = 1'b0;
        end
        // R8: write during pending is discarded.
        wr_slot(3'd1, 8'h99, 22'h09999);
        wr_slot(3'd0, 8'h98, 22'h09898);
        commit(1'b0, 1'b1);
        tick();
        chk(done == 1, "R7", "done sticky", done, 1);
        rd_status();

        // R6/R8: re-arm with no new writes commits nothing.
        do_arm();
        commit(1'b1, 1'b0);   // R7: read in the last cycle keeps done
        rd_status();

        // All five slots, read coinciding with nothing.
        for (int i = 0; i < 5; i++) wr_slot(3'(i), 8'(8'hA0 + i), 22'(22'h20000 + i));
        do_arm();
        commit(1'b0, 1'b0);
        rd_status();

        // Random rounds.
        for (int r = 0; r < 40; r++) begin
            int nw;
            nw = $urandom_range(0, 7);
            for (int w = 0; w < nw; w++)
                wr_slot(3'($urandom_range(0, 6)), 8'($urandom), 22'($urandom));
            do_arm();
            for (int k = 0; k < int'($urandom_range(0, 6)); k++) begin
                chk(ram_we == 0, "R3", "no write while waiting", ram_we, 0);
                if ($urandom_range(0, 3) == 0)
                    wr_slot(3'($urandom_range(0, 4)), 8'($urandom), 22'($urandom));
                else
                    tick();
            end
            commit(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 1) == 1) rd_status();
            else begin
                tick();
                chk(done == 1, "R7", "done held without read", done, 1);
                rd_status();
            end
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule